// File: doc/BRIEF.md
# Serial Temperature Sensor Slave Emulator

This block stands in for a serial temperature sensor so that a read controller can be exercised without the physical part. A master drives a serial clock and an active-high enable. The emulator answers on its data-out pin with a 16-bit read frame. Each frame carries a 10-bit two's-complement temperature, counted in steps of 0.25 °C, which the surrounding logic supplies on a parallel input. The data-in pin of the real sensor exists only so that wiring matches. The emulator never looks at it.

The serial clock and the enable are asynchronous to the emulator's system clock. Both pass through synchronizers and edge detectors. When enable rises, the emulator captures the temperature into a frame shift register. It drives the leading zero at once. After that it moves one bit forward on each rising serial-clock edge, but the first rising edge of a frame does not move it. This leaves every bit valid across the falling edge where the master samples it. While enable is low, the output-enable is deasserted and the data pin is released to high impedance.

With a 100 MHz system clock and two synchronizer stages, output updates land three system cycles after a serial-clock edge. That keeps serial clocks up to 10 MHz safe.

Top module: `tsense_slave_emu`

## Requirements
- R1: While the synchronized enable is low (and after reset), `sdo_oe` is 0 and `sdo` is high impedance.
- R2: Three system-clock edges after enable rises, `sdo_oe` is 1 and `sdo` drives frame bit 0, which is 0. This happens before any serial-clock edge.
- R3: Frame bits 1 to 10 carry the captured temperature, most significant bit first. Frame bit i is presented after the i-th rising serial-clock edge that follows the first rising edge of the frame.
- R4: Frame bits 11 to 15 each equal the captured temperature's least significant bit.
- R5: `sdo` changes only three system cycles after a rising serial-clock edge, or on an enable change. It holds through falling serial-clock edges.
- R6: The temperature input is sampled only on the enable rising edge. Changes to it during a frame have no effect on the bits driven.
- R7: If enable stays high for more than 16 serial clocks, `sdo` keeps driving the temperature LSB.
- R8: A new frame, starting again from the leading zero, begins only after enable has been low and then rises again. An aborted partial frame leaves no trace.
- R9: The synchronized serial-clock and enable rise and fall indications are never both asserted for one signal in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, asynchronous |
| cs_en | input | 1 | Active-high chip enable from the master, asynchronous |
| sdi | input | 1 | Serial data from the master, accepted and ignored |
| temp_in | input | DATA_W (10) | Two's-complement temperature, 0.25 °C per step |
| sdo | output | 1 | Serial frame data, high impedance while disabled |
| sdo_oe | output | 1 | High while `sdo` is driven |

## Verification
A wrong frame position shows up as a shifted or duplicated bit at the next falling serial-clock edge. The reference model compares the pin on every system cycle, so the wrong value is flagged within three system cycles of the rising edge that should have moved the frame. A capture that has gone stale, or that follows the temperature input, shows up in the middle of the very frame where the input is changed. A frame counter that fails to restart shows up at the first bit of the following frame. An output-enable stuck high shows up in the first idle cycle after enable falls.

// File: rtl/ts_emu_pkg.sv
package ts_emu_pkg;
  localparam int TS_DATA_W = 10;
  localparam int TS_TAIL_W = 5;
  localparam int TS_SYNC_STAGES = 2;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } edge_evt_t;
endpackage

// File: rtl/ts_edge_sync.sv
module ts_edge_sync
  import ts_emu_pkg::*;
#(
  parameter int STAGES = TS_SYNC_STAGES
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin,
  output edge_evt_t evt
);
  logic [STAGES-1:0] chain;
  logic              prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain    <= '0;
      prev_lvl <= 1'b0;
    end else begin
      chain    <= {chain[STAGES-2:0], pin};
      prev_lvl <= chain[STAGES-1];
    end
  end

  always_comb begin
    evt.level = chain[STAGES-1];
    evt.rise  = chain[STAGES-1] & ~prev_lvl;
    evt.fall  = ~chain[STAGES-1] & prev_lvl;
  end

  p_edge_excl_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt.rise, evt.fall}));
  p_rise_follows_low_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    evt.rise |-> !$past(evt.level));
endmodule

// File: rtl/ts_frame_shifter.sv
module ts_frame_shifter #(
  parameter int DATA_W = 10,
  parameter int TAIL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_level,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic [DATA_W-1:0] temp,
  output logic              bit_out,
  output logic              active
);
  localparam int FRAME_W = 1 + DATA_W + TAIL_W;

  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] t);
    return {1'b0, t, {TAIL_W{t[0]}}};
  endfunction

  logic [FRAME_W-1:0] sreg;
  logic               first_pend;
  logic               load_evt;
  logic               shift_evt;
  logic               arm_evt;

  assign load_evt  = cs_level & cs_rise;
  assign shift_evt = active & cs_level & ~cs_rise & sclk_rise & ~first_pend;
  assign arm_evt   = active & cs_level & ~cs_rise & sclk_rise & first_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg       <= '0;
      active     <= 1'b0;
      first_pend <= 1'b0;
    end else if (!cs_level) begin
      active     <= 1'b0;
      first_pend <= 1'b0;
    end else if (load_evt) begin
      sreg       <= build_frame(temp);
      active     <= 1'b1;
      first_pend <= 1'b1;
    end else if (shift_evt) begin
      sreg <= {sreg[FRAME_W-2:0], sreg[0]};
    end else if (arm_evt) begin
      first_pend <= 1'b0;
    end
  end

  assign bit_out = sreg[FRAME_W-1];

  p_lead_zero_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (active && !bit_out));
  p_next_bit_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (bit_out == $past(sreg[FRAME_W-2])));
  p_hold_between_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (active && cs_level && !shift_evt) |=> $stable(bit_out));
  p_capture_frozen_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (active && cs_level && !shift_evt) |=> $stable(sreg));
  p_tail_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (active && cs_level && (sreg == {FRAME_W{sreg[0]}})) |=> (sreg == $past(sreg)));
  p_fresh_frame_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> !active);
  p_idle_release_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    !cs_level |=> !active);
endmodule

// File: rtl/tsense_slave_emu.sv
module tsense_slave_emu
  import ts_emu_pkg::*;
#(
  parameter int DATA_W = TS_DATA_W,
  parameter int TAIL_W = TS_TAIL_W,
  parameter int SYNC_STAGES = TS_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_en,
  input  logic              sdi,
  input  logic [DATA_W-1:0] temp_in,
  output logic              sdo,
  output logic              sdo_oe
);
  edge_evt_t cs_evt;
  edge_evt_t sclk_evt;
  logic      frame_bit;
  logic      frame_active;

  ts_edge_sync #(.STAGES(SYNC_STAGES)) u_cs_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (cs_en),
    .evt   (cs_evt)
  );

  ts_edge_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (sclk),
    .evt   (sclk_evt)
  );

  ts_frame_shifter #(.DATA_W(DATA_W), .TAIL_W(TAIL_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_level  (cs_evt.level),
    .cs_rise   (cs_evt.rise),
    .sclk_rise (sclk_evt.rise),
    .temp      (temp_in),
    .bit_out   (frame_bit),
    .active    (frame_active)
  );

  assign sdo_oe = frame_active;
  assign sdo    = frame_active ? frame_bit : 1'bz;

  p_oe_tracks_cs_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> cs_evt.level);
endmodule

// File: tb/tb_tsense_slave_emu.sv
module tb_tsense_slave_emu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_en = 1'b0;
  logic       sdi = 1'b0;
  logic [9:0] temp_in = '0;
  wire        sdo;
  wire        sdo_oe;

  int checks = 0;
  int bad = 0;

  always #5 clk = ~clk;

  tsense_slave_emu dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_en(cs_en), .sdi(sdi),
    .temp_in(temp_in), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  // behavioural reference: pin history, frame position, captured word
  bit       h_cs[1:3];
  bit       h_sk[1:3];
  bit       m_act = 0;
  bit       m_pend = 0;
  int       m_idx = 0;
  bit [9:0] m_temp = '0;

  function automatic bit exp_bit(input bit [9:0] t, input int i);
    if (i == 0) return 1'b0;
    if (i <= 10) return t[10 - i];
    return t[0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 1; j <= 3; j++) begin h_cs[j] = 0; h_sk[j] = 0; end
      m_act = 0; m_pend = 0; m_idx = 0;
    end else begin
      if (!h_cs[2]) begin
        m_act = 0; m_pend = 0;
      end else if (!h_cs[3]) begin
        m_act = 1; m_pend = 1; m_idx = 0; m_temp = temp_in;
      end else if (m_act && h_sk[2] && !h_sk[3]) begin
        if (m_pend) m_pend = 0;
        else if (m_idx < 15) m_idx++;
      end
      h_cs[3] = h_cs[2]; h_cs[2] = h_cs[1]; h_cs[1] = cs_en;
      h_sk[3] = h_sk[2]; h_sk[2] = h_sk[1]; h_sk[1] = sclk;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (rst_n) begin
      check(sdo_oe === m_act, "R1", "oe per-cycle", int'(sdo_oe), int'(m_act));
      if (m_act) begin
        string tag;
        tag = (m_idx == 0) ? "R2" : (m_idx <= 10) ? "R3" : "R4";
        check(sdo === exp_bit(m_temp, m_idx), tag, "sdo per-cycle",
              int'(sdo), int'(exp_bit(m_temp, m_idx)));
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input bit [9:0] t, input int nclk,
                           input bit mid_change, input bit [9:0] t2);
    temp_in = t;
    wait_clk(1);
    cs_en = 1'b1;
    wait_clk(4);
    check(sdo_oe === 1'b1 && sdo === 1'b0, "R2", "leading zero before sclk",
          int'(sdo), 0);
    if (mid_change) temp_in = t2;
    for (int i = 0; i < nclk; i++) begin
      sclk = 1'b1;
      wait_clk(5);
      begin
        bit e;
        string tag;
        e = exp_bit(t, (i > 15) ? 15 : i);
        tag = (i >= 16) ? "R7" : mid_change ? "R6" : (i == 0) ? "R2" :
              (i <= 10) ? "R3" : "R4";
        check(sdo === e, tag, $sformatf("frame bit %0d", i), int'(sdo), int'(e));
      end
      sclk = 1'b0;
      wait_clk(5);
    end
    cs_en = 1'b0;
    wait_clk(4);
    check(sdo_oe === 1'b0, "R1", "released after enable low", int'(sdo_oe), 0);
    wait_clk(2);
  endtask

  initial begin
    wait_clk(5);
    check(sdo_oe === 1'b0, "R1", "oe in reset", int'(sdo_oe), 0);
    rst_n = 1'b1;
    wait_clk(6);
    check(sdo_oe === 1'b0, "R1", "oe idle after reset", int'(sdo_oe), 0);
    sdi = 1'b1;
    run_frame(10'h1FF, 16, 0, '0);
    sdi = 1'b0;
    run_frame(10'h200, 16, 0, '0);
    run_frame(10'h155, 16, 0, '0);
    run_frame(10'h001, 16, 0, '0);
    run_frame(10'h3FE, 16, 0, '0);
    run_frame(10'h0AA, 16, 1, 10'h355);   // R6
    run_frame(10'h2C3, 22, 0, '0);        // R7
    run_frame(10'h1C4, 22, 0, '0);        // R7 with LSB zero
    run_frame(10'h2AB, 7, 0, '0);         // R8 aborted frame
    run_frame(10'h054, 16, 0, '0);        // R8 restart from leading zero
    run_frame(10'h3C1, 16, 0, '0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule